// File: doc/BRIEF.md
# E1 Channel Timing and Blocking Generator

This block produces the per-timeslot timing strobes for one direction of an E1 path. It runs on the 2.048 MHz bit clock. It takes a frame-boundary pulse and from it derives three outputs:

- a channel clock that marks the last bit of every timeslot;
- a per-channel blocking output;
- a sync pulse that marks either every frame or the start of each 16-frame multiframe.

A host loads a 32-bit channel mask through four byte-wide write registers. A G.802 enable adds a fixed high mark on the first bit of timeslot 26.

A two-state controller governs the block. In `ST_IDLE` it waits for the first frame pulse, and all outputs stay low. The transition `IDLE_TO_RUN` is taken on the first `sync_in`. In `ST_RUN` the bit, timeslot and multiframe counters free-run and drive the outputs. A further `sync_in` realigns the counters but leaves the state unchanged (`RUN_HOLD`). Reset is the only way back to `ST_IDLE`.

Mask writes go into a shadow bank. The shadow is copied to the active mask only at a frame boundary, so no frame ever shows a mix of old and new settings.

Top module: `e1_chan_timing`

## Requirements
- R1: After reset and until the first `sync_in`, `chan_clk`, `chan_blk` and `sync_out` are all low.
- R2: The cycle in which `sync_in` is high is bit index 0 of timeslot 0. Bit positions then advance once per clock, with 8 bits per timeslot and 32 timeslots (256 clocks) per frame, wrapping to bit 0 of timeslot 0.
- R3: In `ST_RUN`, `chan_clk` is high exactly during bit index 7 (the LSB) of every timeslot.
- R4: In `ST_RUN`, during timeslot k (channel k+1), `chan_blk` equals bit k of the active 32-bit mask. Write address n (0..3) holds mask bits 8n+7..8n, with data bit b mapping to timeslot 8n+b. Address 0 bit 0 is channel 1, and address 3 bit 7 is channel 32.
- R5: With `g802_en` high, `chan_blk` is high during bit index 0 of timeslot 26 whatever the mask holds. The other bits of timeslot 26 still follow the mask.
- R6: A mask write appears on `chan_blk` only from the next frame start. While in `ST_IDLE`, the active mask follows the shadow registers one cycle after the write.
- R7: With `mf_sel` low, `sync_out` is high for one clock at bit 0 of timeslot 0 of every frame.
- R8: With `mf_sel` high, `sync_out` is high only at bit 0 of timeslot 0 of frame 0 of a 16-frame multiframe. Frame 0 is the frame started by the first `sync_in` after reset.
- R9: A `sync_in` in `ST_RUN` away from bit 0 of timeslot 0 makes the next cycle bit index 1 of timeslot 0, and it advances the multiframe count by one. A `sync_in` at bit 0 of timeslot 0 changes nothing.
- R10: `rst_n` low returns the block to `ST_IDLE` and clears both the shadow and the active mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Frame-boundary pulse, one clock wide |
| mf_sel | input | 1 | Sync output mode: 0 frame, 1 multiframe |
| g802_en | input | 1 | Force block high on bit 0 of timeslot 26 |
| wr_en | input | 1 | Mask register write strobe |
| wr_addr | input | 2 | Mask register select |
| wr_data | input | 8 | Mask register write data |
| chan_clk | output | 1 | High on the LSB of each timeslot |
| chan_blk | output | 1 | Per-channel blocking output |
| sync_out | output | 1 | Frame or multiframe boundary pulse |

## Verification
The assertions assume that `sync_in` is a single-cycle pulse, and that `mf_sel` and `g802_en` are quasi-static configuration inputs. The bench changes `mf_sel` and `g802_en` only between frames, and it raises `sync_in` for one cycle at a time: at aligned frame starts, at entry from idle, and once deliberately mid-frame to exercise realignment. Mask writes are issued at arbitrary positions within a frame, so the shadow-to-active handover is covered.

// File: rtl/e1t_pkg.sv
package e1t_pkg;
    parameter int BITS_PER_SLOT = 8;
    parameter int SLOTS         = 32;
    parameter int MF_FRAMES     = 16;
    parameter int G802_SLOT     = 26;
    parameter int MASK_REG_W    = 8;

    localparam int BIT_W     = $clog2(BITS_PER_SLOT);
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int MF_W      = $clog2(MF_FRAMES);
    localparam int MASK_REGS = SLOTS / MASK_REG_W;
    localparam int ADDR_W    = $clog2(MASK_REGS);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } e1t_state_t;
endpackage

// File: rtl/e1t_slot_counter.sv
module e1t_slot_counter
    import e1t_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              sync_in,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              frame_last,
    output logic              frame_first
);
    localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BITS_PER_SLOT - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            slot_idx <= '0;
        end else if (sync_in) begin
            // the pulse cycle is bit 0 of slot 0; the next cycle is bit 1
            bit_idx  <= BIT_W'(1);
            slot_idx <= '0;
        end else if (run) begin
            if (bit_idx == BIT_LAST) begin
                bit_idx  <= '0;
                slot_idx <= (slot_idx == SLOT_LAST) ? '0 : slot_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end else begin
            bit_idx  <= '0;
            slot_idx <= '0;
        end
    end

    assign frame_last  = (bit_idx == BIT_LAST) && (slot_idx == SLOT_LAST);
    assign frame_first = (bit_idx == '0) && (slot_idx == '0);

    // R2: bit position steps by one inside a timeslot
    a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sync_in && bit_idx != BIT_LAST) |=> (bit_idx == BIT_W'($past(bit_idx) + 1)));

    // R2: frame wraps to slot 0 bit 0
    a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sync_in && frame_last) |=> frame_first);

    // R9: realignment lands on bit 1 of slot 0
    a_r9_realign: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (bit_idx == BIT_W'(1) && slot_idx == '0));
endmodule

// File: rtl/e1t_mf_counter.sv
module e1t_mf_counter
    import e1t_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            sync_in,
    input  logic            frame_last,
    input  logic            frame_first,
    output logic [MF_W-1:0] mf_idx
);
    localparam logic [MF_W-1:0] MF_LAST = MF_W'(MF_FRAMES - 1);

    logic advance;

    always_comb begin
        if (sync_in) advance = run && !frame_first;
        else         advance = run && frame_last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            mf_idx <= '0;
        end else if (advance) begin
            mf_idx <= (mf_idx == MF_LAST) ? '0 : mf_idx + 1'b1;
        end
    end

    // R8: frame count changes only at a frame boundary or on a realign
    a_r8_mf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sync_in && !frame_last) |=> $stable(mf_idx));

    // R9: aligned sync in run leaves the multiframe count alone
    a_r9_aligned_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sync_in && frame_first) |=> $stable(mf_idx));
endmodule

// File: rtl/e1t_mask_bank.sv
module e1t_mask_bank
    import e1t_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [MASK_REG_W-1:0] wr_data,
    input  logic [SLOT_W-1:0]     slot_idx,
    output logic                  blk_bit
);
    logic [SLOTS-1:0] shadow_flat;
    logic [SLOTS-1:0] active_q;

    for (genvar r = 0; r < MASK_REGS; r++) begin : g_reg
        logic [MASK_REG_W-1:0] reg_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                reg_q <= '0;
            else if (wr_en && wr_addr == ADDR_W'(r))
                reg_q <= wr_data;
        end
        assign shadow_flat[r*MASK_REG_W +: MASK_REG_W] = reg_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    active_q <= '0;
        else if (load) active_q <= shadow_flat;
    end

    assign blk_bit = active_q[slot_idx];

    // R6: active mask never changes inside a frame
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active_q));
endmodule

// File: rtl/e1_chan_timing.sv
module e1_chan_timing
    import e1t_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sync_in,
    input  logic                  mf_sel,
    input  logic                  g802_en,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [MASK_REG_W-1:0] wr_data,
    output logic                  chan_clk,
    output logic                  chan_blk,
    output logic                  sync_out
);
    localparam logic [BIT_W-1:0]  BIT_LAST = BIT_W'(BITS_PER_SLOT - 1);
    localparam logic [SLOT_W-1:0] G_SLOT   = SLOT_W'(G802_SLOT);

    e1t_state_t state_q, state_d;
    logic              run;
    logic [BIT_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic [MF_W-1:0]   mf_idx;
    logic              frame_last, frame_first;
    logic              blk_bit, mask_load;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sync_in) state_d = ST_RUN;   // IDLE_TO_RUN
            ST_RUN:  state_d = ST_RUN;                // RUN_HOLD
        endcase
    end

    assign run       = (state_q == ST_RUN);
    assign mask_load = !run || sync_in || frame_last;

    e1t_slot_counter u_slot (
        .clk(clk), .rst_n(rst_n), .run(run), .sync_in(sync_in),
        .bit_idx(bit_idx), .slot_idx(slot_idx),
        .frame_last(frame_last), .frame_first(frame_first)
    );

    e1t_mf_counter u_mf (
        .clk(clk), .rst_n(rst_n), .run(run), .sync_in(sync_in),
        .frame_last(frame_last), .frame_first(frame_first), .mf_idx(mf_idx)
    );

    e1t_mask_bank u_mask (
        .clk(clk), .rst_n(rst_n), .load(mask_load),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .slot_idx(slot_idx), .blk_bit(blk_bit)
    );

    always_comb begin
        chan_clk = 1'b0;
        chan_blk = 1'b0;
        sync_out = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                chan_clk = (bit_idx == BIT_LAST);
                chan_blk = blk_bit ||
                           (g802_en && slot_idx == G_SLOT && bit_idx == '0);
                sync_out = frame_first && (!mf_sel || mf_idx == '0);
            end
        endcase
    end

    // R3: channel clock is a single-cycle strobe
    a_r3_clk_single: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clk |=> !chan_clk);

    // R7: sync output is a single-cycle strobe
    a_r7_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> !sync_out);

    // R1: idle holds every output low until a frame pulse arrives
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !sync_in) |=> !(chan_clk || chan_blk || sync_out));

    // R10: leaving reset always starts in idle
    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_IDLE));
endmodule

// File: tb/tb_e1_chan_timing.sv
module tb_e1_chan_timing;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b0, mf_sel = 1'b0, g802_en = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       chan_clk, chan_blk, sync_out;

    always #10 clk = ~clk;

    e1_chan_timing dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .mf_sel(mf_sel),
        .g802_en(g802_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .chan_clk(chan_clk), .chan_blk(chan_blk), .sync_out(sync_out)
    );

    int n_chk = 0, n_err = 0;
    // bench model state
    bit          m_run = 0;
    int          m_pos = 0, m_fr = 0;
    logic [31:0] m_shadow = '0, m_active = '0;
    int          sync_seen = 0, blk_seen = 0;

    // {mask[31:0], g802, mf, sync_every_frame, frames[2:0]}
    localparam logic [37:0] VEC [6] = '{
        {32'h0000_0000, 1'b0, 1'b0, 1'b1, 3'd2},
        {32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 3'd2},
        {32'hA5C3_0F81, 1'b1, 1'b0, 1'b0, 3'd2},
        {32'h8000_0001, 1'b1, 1'b1, 1'b0, 3'd3},
        {32'h0400_0000, 1'b1, 1'b1, 1'b1, 3'd2},
        {32'h1234_5678, 1'b0, 1'b1, 1'b0, 3'd4}
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s got %b exp %b (pos %0d frame %0d)", tag, act, exp, m_pos, m_fr);
        end
    endtask

    task automatic step(input bit s, input bit we, input int a, input logic [7:0] d);
        logic [31:0] nxt_active;
        logic e_clk, e_blk, e_sync;
        int b, t;
        sync_in = s; wr_en = we; wr_addr = a[1:0]; wr_data = d;
        @(negedge clk);
        b = m_pos % 8; t = m_pos / 8;
        e_clk  = m_run && (b == 7);
        e_blk  = m_run && (m_active[t] || (g802_en && t == 26 && b == 0));
        e_sync = m_run && (m_pos == 0) && (!mf_sel || m_fr == 0);
        chk("R2 R3 chan_clk", chan_clk, e_clk);
        chk("R4 R5 R6 chan_blk", chan_blk, e_blk);
        chk("R7 R8 R9 sync_out", sync_out, e_sync);
        if (sync_out) sync_seen++;
        if (chan_blk) blk_seen++;
        @(posedge clk);
        nxt_active = m_active;
        if (!m_run || s || m_pos == 255) nxt_active = m_shadow;
        if (we) m_shadow[a*8 +: 8] = d;
        m_active = nxt_active;
        if (s) begin
            if (!m_run) m_fr = 0;
            else if (m_pos != 0) m_fr = (m_fr + 1) % 16;
            m_pos = 1; m_run = 1;
        end else if (m_run) begin
            if (m_pos == 255) m_fr = (m_fr + 1) % 16;
            m_pos = (m_pos + 1) % 256;
        end
        #1;
        sync_in = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 R10: outputs low while in reset
        chk("R1 R10 reset chan_clk", chan_clk, 1'b0);
        chk("R1 R10 reset chan_blk", chan_blk, 1'b0);
        chk("R1 R10 reset sync_out", sync_out, 1'b0);
        m_run = 0; m_pos = 0; m_fr = 0; m_shadow = '0; m_active = '0;
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(120000 * 20);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();

        // R1: idle without a frame pulse, even with mask and override set
        g802_en = 1'b1;
        step(0, 1, 3, 8'hFF);
        blk_seen = 0;
        for (int i = 0; i < 300; i++) step(0, 0, 0, 0);
        chk("R1 idle no blk", blk_seen != 0, 1'b0);
        g802_en = 1'b0;

        // vector table walk
        for (int v = 0; v < 6; v++) begin
            logic [31:0] mk;
            logic g, mf, se;
            logic [2:0] nf;
            {mk, g, mf, se, nf} = VEC[v];
            g802_en = g; mf_sel = mf;
            for (int r = 0; r < 4; r++) step(0, 1, r, mk[r*8 +: 8]);
            for (int f = 0; f < int'(nf); f++)
                for (int c = 0; c < 256; c++)
                    step(!m_run || (se && m_pos == 0), 0, 0, 0);
        end

        // R6: a write in mid-frame is not visible until the next frame
        g802_en = 1'b0; mf_sel = 1'b0;
        while (m_pos != 8) step(0, 0, 0, 0);
        step(0, 1, 0, 8'h00);          // clear channels 1..8 at slot 1
        while (m_pos != 255) step(0, 0, 0, 0);
        step(0, 1, 2, 8'hFF);          // write on the boundary edge itself
        for (int c = 0; c < 512; c++) step(0, 0, 0, 0);

        // R9: misaligned frame pulse in run
        while (m_pos != 100) step(0, 0, 0, 0);
        step(1, 0, 0, 0);
        for (int c = 0; c < 6; c++) step(0, 0, 0, 0);
        @(negedge clk);
        chk("R9 LSB six clocks after realign", chan_clk, 1'b1);
        @(posedge clk); #1;
        m_pos = m_pos + 1;
        while (m_pos != 0) step(0, 0, 0, 0);
        step(1, 0, 0, 0);              // aligned pulse: no change
        for (int c = 0; c < 300; c++) step(0, 0, 0, 0);

        // R8: exactly two multiframe pulses in 32 frames
        mf_sel = 1'b1;
        while (m_pos != 0) step(0, 0, 0, 0);
        sync_seen = 0;
        for (int c = 0; c < 32 * 256; c++) step(0, 0, 0, 0);
        chk("R8 two pulses per 32 frames", sync_seen == 2, 1'b1);

        // R7: frame mode gives one pulse per frame
        mf_sel = 1'b0;
        sync_seen = 0;
        for (int c = 0; c < 4 * 256; c++) step(0, 0, 0, 0);
        chk("R7 four pulses per 4 frames", sync_seen == 4, 1'b1);

        // R10: reset mid-run clears the mask
        for (int r = 0; r < 4; r++) step(0, 1, r, 8'hFF);
        for (int c = 0; c < 300; c++) step(0, 0, 0, 0);
        do_reset();
        step(1, 0, 0, 0);
        blk_seen = 0;
        for (int c = 0; c < 512; c++) step(0, 0, 0, 0);
        chk("R10 mask cleared by reset", blk_seen != 0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule